// File: doc/BRIEF.md
# Clock Frequency Window Monitor

This block supervises an externally supplied clock (`mon_clk`) against a free-running internal reference oscillator clock (`ref_clk`). It judges whether the external frequency lies inside a two-sided ratio window, above one quarter and below four times the reference frequency. When the external clock leaves that window, the block raises a sticky fail flag. It also moves the clock it hands to downstream logic from the external source to the reference oscillator, which then serves as a limp-mode clock.

The measurement runs in the reference domain. A Gray-coded edge counter runs in the monitored domain and is synchronized into the reference domain. Its advance is accumulated over a fixed window of `WIN_CYC` reference cycles, with the sum saturating at the upper bound. The verdict for the very first window after reset is discarded. The fail flag and the limp selection stay set until an asynchronous reset, or until a write-one-to-clear strobe aimed at status bit 0. The output clock comes from a glitch-free two-input clock multiplexer. Each input of that multiplexer has an enable that is synchronized in its own clock domain.

Top module: `clk_window_monitor`

## Requirements
- R1: When the monitored clock delivers more than `LO_CNT` (16) and fewer than `HI_CNT` (256) rising edges per window of `WIN_CYC` (64) reference cycles, `fail_o` stays 0, `limp_o` stays 0 and `clk_o` follows `mon_clk`.
- R2: When the window edge count is at most `LO_CNT` (a clock slower than about a quarter of the reference), `fail_o` becomes 1 at the end of the first evaluated window.
- R3: When the window edge count reaches `HI_CNT` or more (a clock faster than about four times the reference), `fail_o` becomes 1. The accumulated count saturates at `HI_CNT`, so very fast clocks also fail.
- R4: A monitored clock that does not toggle at all yields a count of zero and is reported as a fail.
- R5: `fail_o` stays 0 for the first `2*WIN_CYC` reference cycles after reset release. The first window after reset is never evaluated.
- R6: Once set, `fail_o` and `limp_o` stay set even after the monitored clock returns to a valid frequency.
- R7: A reference-cycle pulse on `clr_wr_i` with `clr_wdata_i` = 1 (status bit 0 written with one) clears `fail_o` at that edge. With `clr_wdata_i` = 0, the write has no effect.
- R8: While the fail flag is set, the limp enable rises, `limp_o` reads 1 and `clk_o` follows `ref_clk`.
- R9: The two clock enables of the multiplexer are never on together. After a clear, `clk_o` returns to `mon_clk` and `limp_o` to 0.
- R10: During and directly after reset, `fail_o` and `limp_o` are 0 and `clk_o` follows `mon_clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Internal reference oscillator clock; the measurement domain and the limp clock |
| mon_clk | input | 1 | Externally supplied clock under supervision |
| arst_n | input | 1 | Asynchronous active-low reset for all domains |
| clr_wr_i | input | 1 | Status write strobe, one `ref_clk` cycle wide |
| clr_wdata_i | input | 1 | Value written to status bit 0; a one clears the fail flag |
| fail_o | output | 1 | Sticky fail flag (status bit 0) |
| limp_o | output | 1 | High while the multiplexer drives the reference clock |
| clk_o | output | 1 | Selected clock for downstream domains |

## Verification
The bench sweeps the monitored period across the whole range, from far above four times the reference down to far below a quarter of it. At each point it works out the expected edge count per window by arithmetic, and it skips only the narrow bands where a single edge of phase uncertainty could flip the verdict. A design that counts past the upper bound without saturating, or that compares with the wrong inequality, fails at the fast end. A stopped clock checks that zero edges count as a fail rather than stalling the measurement. A multiplexer that waits for the dead clock to release its own enable would never switch, and the stopped-clock case catches that too. The bench also checks the quiet first window, the stickiness after the clock recovers, a clear write carrying a zero, and the return to the monitored clock after a real clear. Each of these would show up as a premature, lost or stuck flag on the ports.

// File: rtl/cfwm_pkg.sv
`timescale 1ns/1ps
package cfwm_pkg;

  // Verdict for one window: outside the open interval (lo, hi) is a fail.
  function automatic logic out_of_window(input int unsigned cnt,
                                         input int unsigned lo,
                                         input int unsigned hi);
    return (cnt <= lo) || (cnt >= hi);
  endfunction

  // Saturating accumulate used by the window counter.
  function automatic int unsigned sat_sum(input int unsigned a,
                                          input int unsigned b,
                                          input int unsigned cap);
    int unsigned s;
    s = a + b;
    return (s > cap) ? cap : s;
  endfunction

endpackage

// File: rtl/cfwm_meter.sv
`timescale 1ns/1ps
module cfwm_meter
  import cfwm_pkg::*;
#(
  parameter int WIN_CYC = 64,
  parameter int HI_CNT  = 256,
  parameter int GRAY_W  = 8,
  localparam int ACC_W  = $clog2(HI_CNT + 1),
  localparam int WIN_W  = $clog2(WIN_CYC)
) (
  input  logic             ref_clk,
  input  logic             mon_clk,
  input  logic             arst_n,
  output logic             eval_o,
  output logic [ACC_W-1:0] count_o
);

  function automatic logic [GRAY_W-1:0] to_gray(input logic [GRAY_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [GRAY_W-1:0] from_gray(input logic [GRAY_W-1:0] g);
    logic [GRAY_W-1:0] b;
    b[GRAY_W-1] = g[GRAY_W-1];
    for (int i = GRAY_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // Monitored domain: free-running edge counter, published in Gray code.
  logic [GRAY_W-1:0] mon_bin_q, mon_gray_q, mon_bin_nx;
  assign mon_bin_nx = mon_bin_q + GRAY_W'(1);

  always_ff @(posedge mon_clk or negedge arst_n) begin
    if (!arst_n) begin
      mon_bin_q  <= '0;
      mon_gray_q <= '0;
    end else begin
      mon_bin_q  <= mon_bin_nx;
      mon_gray_q <= to_gray(mon_bin_nx);
    end
  end

  // Reference domain: two-flop capture, per-cycle advance, window sum.
  logic [GRAY_W-1:0] gsync1_q, gsync2_q, prev_bin_q, cur_bin, delta;
  logic [ACC_W-1:0]  acc_q, acc_sum, count_q;
  logic [WIN_W-1:0]  win_q;
  logic              win_end, armed_q, eval_q;

  assign cur_bin = from_gray(gsync2_q);
  assign delta   = cur_bin - prev_bin_q;
  assign acc_sum = ACC_W'(sat_sum(32'(acc_q), 32'(delta), HI_CNT));
  assign win_end = (win_q == WIN_W'(WIN_CYC - 1));

  always_ff @(posedge ref_clk or negedge arst_n) begin
    if (!arst_n) begin
      gsync1_q   <= '0;
      gsync2_q   <= '0;
      prev_bin_q <= '0;
      win_q      <= '0;
      acc_q      <= '0;
      count_q    <= '0;
      armed_q    <= 1'b0;
      eval_q     <= 1'b0;
    end else begin
      gsync1_q   <= mon_gray_q;
      gsync2_q   <= gsync1_q;
      prev_bin_q <= cur_bin;
      win_q      <= win_end ? '0 : win_q + WIN_W'(1);
      eval_q     <= win_end & armed_q;
      if (win_end) begin
        acc_q   <= '0;
        count_q <= acc_sum;
        armed_q <= 1'b1;
      end else begin
        acc_q   <= acc_sum;
      end
    end
  end

  assign eval_o  = eval_q;
  assign count_o = count_q;

  // R3: the published window count never exceeds the saturation bound.
  p_count_cap_r3: assert property (@(posedge ref_clk) disable iff (!arst_n)
    count_q <= ACC_W'(HI_CNT));

  // R1: a verdict strobe lasts exactly one reference cycle.
  p_eval_single_r1: assert property (@(posedge ref_clk) disable iff (!arst_n)
    eval_q |=> !eval_q);

  // R4: inside a window the running sum never decreases.
  p_acc_monotone_r4: assert property (@(posedge ref_clk) disable iff (!arst_n)
    !win_end |=> (acc_q >= $past(acc_q)));

endmodule

// File: rtl/cfwm_verdict.sv
`timescale 1ns/1ps
module cfwm_verdict
  import cfwm_pkg::*;
#(
  parameter int LO_CNT = 16,
  parameter int HI_CNT = 256,
  localparam int ACC_W = $clog2(HI_CNT + 1)
) (
  input  logic             ref_clk,
  input  logic             arst_n,
  input  logic             eval_i,
  input  logic [ACC_W-1:0] count_i,
  input  logic             clr_wr_i,
  input  logic             clr_wdata_i,
  output logic             fail_o
);

  logic bad_win, clr_hit, fail_q;

  assign bad_win = eval_i && out_of_window(32'(count_i), LO_CNT, HI_CNT);
  assign clr_hit = clr_wr_i && clr_wdata_i;

  // A new fail outranks a clear landing in the same cycle.
  always_ff @(posedge ref_clk or negedge arst_n) begin
    if (!arst_n)      fail_q <= 1'b0;
    else if (bad_win) fail_q <= 1'b1;
    else if (clr_hit) fail_q <= 1'b0;
  end

  assign fail_o = fail_q;

  // R6: without a one written to bit 0 the flag holds.
  p_fail_sticky_r6: assert property (@(posedge ref_clk) disable iff (!arst_n)
    (fail_q && !clr_hit) |=> fail_q);

  // R7: a write of one clears the flag unless a new fail arrives with it.
  p_clear_w1c_r7: assert property (@(posedge ref_clk) disable iff (!arst_n)
    (fail_q && clr_hit && !bad_win) |=> !fail_q);

  // R2: the flag only rises right after a verdict strobe.
  p_fail_origin_r2: assert property (@(posedge ref_clk) disable iff (!arst_n)
    $rose(fail_q) |-> $past(eval_i));

endmodule

// File: rtl/cfwm_clk_mux.sv
`timescale 1ns/1ps
module cfwm_clk_mux (
  input  logic mon_clk,
  input  logic ref_clk,
  input  logic arst_n,
  input  logic sel_ref_i,
  output logic clk_o,
  output logic ref_on_o
);

  logic r_s1_q, r_en_q, m_s1_q, m_en_q;

  // Reference branch: posedge capture, negedge enable.
  always_ff @(posedge ref_clk or negedge arst_n) begin
    if (!arst_n) r_s1_q <= 1'b0;
    else         r_s1_q <= sel_ref_i & ~m_en_q;
  end

  always_ff @(negedge ref_clk or negedge arst_n) begin
    if (!arst_n) r_en_q <= 1'b0;
    else         r_en_q <= r_s1_q;
  end

  // Monitored branch: starts enabled. The select clears it asynchronously,
  // so a dead monitored clock cannot block the switchover.
  always_ff @(posedge mon_clk or negedge arst_n or posedge sel_ref_i) begin
    if (!arst_n)        m_s1_q <= 1'b1;
    else if (sel_ref_i) m_s1_q <= 1'b0;
    else                m_s1_q <= ~r_en_q;
  end

  always_ff @(negedge mon_clk or negedge arst_n or posedge sel_ref_i) begin
    if (!arst_n)        m_en_q <= 1'b1;
    else if (sel_ref_i) m_en_q <= 1'b0;
    else                m_en_q <= m_s1_q;
  end

  assign clk_o    = (mon_clk & m_en_q) | (ref_clk & r_en_q);
  assign ref_on_o = r_en_q;

  // R9: the two clock enables are never on together.
  p_enables_exclusive_r9: assert property (@(posedge ref_clk) disable iff (!arst_n)
    !(m_en_q && r_en_q));

  // R8: the limp enable only rises after a select request.
  p_limp_needs_select_r8: assert property (@(posedge ref_clk) disable iff (!arst_n)
    $rose(r_en_q) |-> $past(sel_ref_i));

endmodule

// File: rtl/clk_window_monitor.sv
`timescale 1ns/1ps
module clk_window_monitor
  import cfwm_pkg::*;
#(
  parameter int WIN_CYC  = 64,
  parameter int LO_CNT   = 16,
  parameter int HI_CNT   = 256,
  parameter int GRAY_W   = 8,
  localparam int ACC_W   = $clog2(HI_CNT + 1),
  localparam int SINCE_W = $clog2(2 * WIN_CYC + 1)
) (
  input  logic ref_clk,
  input  logic mon_clk,
  input  logic arst_n,
  input  logic clr_wr_i,
  input  logic clr_wdata_i,
  output logic fail_o,
  output logic limp_o,
  output logic clk_o
);

  logic             eval_w;
  logic [ACC_W-1:0] count_w;
  logic             fail_w;
  logic             ref_on_w;

  cfwm_meter #(
    .WIN_CYC (WIN_CYC),
    .HI_CNT  (HI_CNT),
    .GRAY_W  (GRAY_W)
  ) u_meter (
    .ref_clk (ref_clk),
    .mon_clk (mon_clk),
    .arst_n  (arst_n),
    .eval_o  (eval_w),
    .count_o (count_w)
  );

  cfwm_verdict #(
    .LO_CNT (LO_CNT),
    .HI_CNT (HI_CNT)
  ) u_verdict (
    .ref_clk     (ref_clk),
    .arst_n      (arst_n),
    .eval_i      (eval_w),
    .count_i     (count_w),
    .clr_wr_i    (clr_wr_i),
    .clr_wdata_i (clr_wdata_i),
    .fail_o      (fail_w)
  );

  cfwm_clk_mux u_mux (
    .mon_clk   (mon_clk),
    .ref_clk   (ref_clk),
    .arst_n    (arst_n),
    .sel_ref_i (fail_w),
    .clk_o     (clk_o),
    .ref_on_o  (ref_on_w)
  );

  assign fail_o = fail_w;
  assign limp_o = ref_on_w;

  // Independent count of reference cycles since reset, for the quiet window.
  logic [SINCE_W-1:0] since_q;
  always_ff @(posedge ref_clk or negedge arst_n) begin
    if (!arst_n)                                  since_q <= '0;
    else if (since_q != SINCE_W'(2 * WIN_CYC))    since_q <= since_q + SINCE_W'(1);
  end

  // R5: no fail is reported before two full windows have elapsed.
  p_quiet_start_r5: assert property (@(posedge ref_clk) disable iff (!arst_n)
    (since_q < SINCE_W'(2 * WIN_CYC)) |-> !fail_w);

endmodule

// File: tb/clk_window_monitor_tb.sv
`timescale 1ns/1ps
module clk_window_monitor_tb;

  localparam int REF_PERIOD = 40;
  localparam int WIN        = 64;
  localparam int LIMIT_CYC  = 150000;

  logic ref_clk   = 1'b0;
  logic mon_clk   = 1'b0;
  logic arst_n    = 1'b0;
  logic clr_wr    = 1'b0;
  logic clr_wdata = 1'b0;
  logic fail, limp, clk_out;

  int vectors     = 0;
  int miscompares = 0;
  int mon_half    = 20;
  bit mon_run     = 1'b1;

  clk_window_monitor u_dut (
    .ref_clk     (ref_clk),
    .mon_clk     (mon_clk),
    .arst_n      (arst_n),
    .clr_wr_i    (clr_wr),
    .clr_wdata_i (clr_wdata),
    .fail_o      (fail),
    .limp_o      (limp),
    .clk_o       (clk_out)
  );

  always #(REF_PERIOD / 2) ref_clk = ~ref_clk;

  initial begin
    forever begin
      if (mon_run) #(mon_half) mon_clk = ~mon_clk;
      else         #7;
    end
  end

  task automatic check(input string req, input string what, input logic got, input logic exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s %s: got %b expected %b at %0t", req, what, got, exp, $time);
    end
  endtask

  task automatic ref_cycles(input int n);
    repeat (n) @(negedge ref_clk);
  endtask

  task automatic do_reset();
    arst_n = 1'b0; clr_wr = 1'b0; clr_wdata = 1'b0;
    #(3 * REF_PERIOD);
    @(negedge ref_clk);
    arst_n = 1'b1;
  endtask

  task automatic write_status(input logic d);
    @(negedge ref_clk);
    clr_wr = 1'b1; clr_wdata = d;
    @(negedge ref_clk);
    clr_wr = 1'b0; clr_wdata = 1'b0;
  endtask

  task automatic check_src_ref(input string req);
    @(posedge ref_clk); #1;
    check(req, "clk_o high with ref_clk", clk_out, 1'b1);
    @(negedge ref_clk); #1;
    check(req, "clk_o low with ref_clk", clk_out, 1'b0);
  endtask

  task automatic check_src_mon(input string req);
    @(posedge mon_clk); #1;
    check(req, "clk_o high with mon_clk", clk_out, 1'b1);
    @(negedge mon_clk); #1;
    check(req, "clk_o low with mon_clk", clk_out, 1'b0);
  endtask

  initial begin
    #(LIMIT_CYC * REF_PERIOD);
    vectors++; miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    // R10: reset state
    mon_half = 20; mon_run = 1'b1; arst_n = 1'b0;
    #(2 * REF_PERIOD + 3);
    check("R10", "fail_o in reset", fail, 1'b0);
    check("R10", "limp_o in reset", limp, 1'b0);
    @(negedge ref_clk); arst_n = 1'b1;
    ref_cycles(4);
    check("R10", "fail_o after reset", fail, 1'b0);
    check_src_mon("R10");

    // R5 and R4: stopped monitored clock
    mon_run = 1'b0;
    do_reset();
    ref_cycles(100);
    check("R5", "fail_o at cycle 100", fail, 1'b0);
    ref_cycles(20);
    check("R5", "fail_o at cycle 120", fail, 1'b0);
    ref_cycles(40);
    check("R4", "fail_o stopped clock", fail, 1'b1);
    check("R8", "limp_o stopped clock", limp, 1'b1);
    check_src_ref("R8");

    // R6: clock recovers, flag stays
    mon_half = 20; mon_run = 1'b1;
    ref_cycles(3 * WIN);
    check("R6", "fail_o after recovery", fail, 1'b1);
    check("R6", "limp_o after recovery", limp, 1'b1);

    // R7: zero written to bit 0 is ignored, one clears
    write_status(1'b0); #1;
    check("R7", "fail_o after zero write", fail, 1'b1);
    ref_cycles(2);
    check("R7", "limp_o after zero write", limp, 1'b1);
    write_status(1'b1); #1;
    check("R7", "fail_o after one write", fail, 1'b0);

    // R9: return to the monitored clock
    ref_cycles(10);
    check("R9", "limp_o after clear", limp, 1'b0);
    check_src_mon("R9");
    ref_cycles(3 * WIN);
    check("R1", "fail_o stays clear with good clock", fail, 1'b0);

    // R1/R2/R3: period sweep, expected count = REF_PERIOD*WIN / Tmon
    for (int t = 6; t <= 250; t += 2) begin
      real e;
      e = real'(REF_PERIOD * WIN) / real'(t);
      mon_half = t / 2; mon_run = 1'b1;
      do_reset();
      ref_cycles(200);
      if (e >= 18.0 && e <= 254.0) begin
        check("R1", $sformatf("fail_o T=%0d", t), fail, 1'b0);
        check("R1", $sformatf("limp_o T=%0d", t), limp, 1'b0);
        check_src_mon("R1");
      end else if (e <= 14.0) begin
        check("R2", $sformatf("fail_o slow T=%0d", t), fail, 1'b1);
        check("R8", $sformatf("limp_o slow T=%0d", t), limp, 1'b1);
        check_src_ref("R8");
      end else if (e >= 258.0) begin
        check("R3", $sformatf("fail_o fast T=%0d", t), fail, 1'b1);
        check("R8", $sformatf("limp_o fast T=%0d", t), limp, 1'b1);
        check_src_ref("R8");
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule